// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block predicts the next fetch address for every instruction a fetch stage issues. It is a small direct-mapped table that sits beside the instruction memory. Each entry remembers the address of one taken branch and the place that branch last jumped to. The fetch address is presented on every cycle, whether or not the instruction turns out to be a branch. The block answers in the same cycle with a predicted next address and a hit flag. A hit therefore marks the instruction as a branch before decode has seen it. On a miss, the prediction is simply the next sequential word.

When a branch resolves later in the pipeline, it reports its own address, its actual target and whether it was taken. A taken branch installs or refreshes its entry, and a not-taken branch leaves the table alone. Two addresses that share an index simply displace one another. This is acceptable because the output is only a guess that the pipeline verifies later.

Top module: `btb_top`

## Requirements
- R1: A lookup is purely combinational on `fetch_pc` and the stored state: `pred_pc` and `pred_hit` are valid in the same cycle for every fetch address, branch or not.
- R2: The entry index is `pc[2 +: log2(ENTRIES)]` (ENTRIES a power of two), for both lookup and update.
- R3: On a miss, `pred_hit` is 0 and `pred_pc` equals `fetch_pc + 4`, wrapping modulo 2^ADDR_W.
- R4: An entry hits only when it is valid and its stored branch address equals `fetch_pc` in every bit. On a hit, `pred_hit` is 1 and `pred_pc` is the stored target.
- R5: Reset (`rst_n` low) invalidates every entry, so every lookup after reset misses until a taken update arrives.
- R6: When `upd_valid` and `upd_taken` are both 1 at a rising edge, the indexed entry becomes valid and holds `upd_pc` and `upd_target`. A lookup in that same cycle still sees the old contents, and the new contents are visible from the next cycle.
- R7: An update with `upd_taken` = 0, or with `upd_valid` = 0, changes no entry.
- R8: A taken update to an index that holds another branch replaces it, and the older branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_taken | input | 1 | The reported branch was taken |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target of the branch |
| pred_pc | output | ADDR_W | Predicted next fetch address |
| pred_hit | output | 1 | Fetch address matched a valid entry |

## Verification
Lookup results are due in the same cycle as the fetch address, with no register on the path. The bench drives inputs on the falling edge and compares both outputs one time unit later, well before the next rising edge. A taken update becomes effective at the next rising edge. The bench's reference model therefore applies the update only after that edge, so a lookup in the update's own cycle is compared against the old contents and the following cycle against the new ones. Alias, wrap-around and not-taken patterns are included among the directed and random steps.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Instructions are word aligned; the index starts above the byte offset.
  localparam int unsigned WORD_SHIFT = 2;
  localparam int unsigned MAX_W = 64;

  // Sequential successor of a fetch address; the caller truncates to its width.
  function automatic logic [MAX_W-1:0] seq_next(input logic [MAX_W-1:0] pc);
    return pc + MAX_W'(4);
  endfunction
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  import btb_pkg::*;
  localparam int unsigned HI_LSB = WORD_SHIFT + IDX_W;

  // Index: low PC bits above the byte offset (simple hash).
  // Tag: every remaining bit, so a hit means an exact address match.
  always_comb begin
    idx = pc[WORD_SHIFT +: IDX_W];
    tag = {pc[ADDR_W-1:HI_LSB], pc[WORD_SHIFT-1:0]};
  end
endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_tgt
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] wr_sel;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (wr_sel[i]) begin
        valid_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_sel[i]) begin
        tag_q[i] <= wr_tag;
        tgt_q[i] <= wr_tgt;
      end
    end
  end

  // Read side sees the registered state, so a same-cycle write is not visible.
  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_tgt   = tgt_q[rd_idx];
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));  // R5

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));  // R6

  AST_IDLE_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));  // R7
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [TAG_W-1:0]  fetch_tag,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_tgt,
  output logic              hit,
  output logic [ADDR_W-1:0] next_pc
);
  import btb_pkg::*;

  logic [ADDR_W-1:0] seq_pc;

  always_comb begin
    seq_pc  = ADDR_W'(seq_next(MAX_W'(fetch_pc)));
    hit     = ent_valid && (ent_tag == fetch_tag);
    next_pc = hit ? ent_tgt : seq_pc;
  end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              upd_valid,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  output logic [ADDR_W-1:0] pred_pc,
  output logic              pred_hit
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  look_idx, upd_idx;
  logic [TAG_W-1:0]  look_tag, upd_tag;
  logic              wr_en;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [ADDR_W-1:0] ent_tgt;

  // Only taken, reported branches install an entry.
  assign wr_en = upd_valid && upd_taken;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_look (
    .pc(fetch_pc), .idx(look_idx), .tag(look_tag)
  );

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split_upd (
    .pc(upd_pc), .idx(upd_idx), .tag(upd_tag)
  );

  btb_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(upd_idx), .wr_tag(upd_tag), .wr_tgt(upd_target),
    .rd_idx(look_idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_tgt(ent_tgt)
  );

  btb_match #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_match (
    .fetch_pc(fetch_pc), .fetch_tag(look_tag),
    .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_tgt(ent_tgt),
    .hit(pred_hit), .next_pc(pred_pc)
  );

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_pc == fetch_pc + ADDR_W'(4)));  // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && fetch_pc == $past(upd_pc))
      |-> (pred_hit && pred_pc == $past(upd_target)));  // R6

  AST_NOT_TAKEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(upd_valid && !upd_taken) && fetch_pc == $past(fetch_pc))
      |-> (pred_hit == $past(pred_hit) && pred_pc == $past(pred_pc)));  // R7
endmodule

// File: tb/btb_top_tb_top.sv
module btb_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NENT = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          upd_valid = 1'b0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic [AW-1:0] upd_target = '0;
  logic [AW-1:0] pred_pc;
  logic          pred_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: full branch address per slot, plain arrays.
  bit            ref_v   [NENT];
  logic [AW-1:0] ref_pc  [NENT];
  logic [AW-1:0] ref_tgt [NENT];

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_top #(.ADDR_W(AW), .ENTRIES(NENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .upd_valid(upd_valid), .upd_taken(upd_taken),
    .upd_pc(upd_pc), .upd_target(upd_target),
    .pred_pc(pred_pc), .pred_hit(pred_hit)
  );

  // R2: slot = word address modulo the entry count
  function automatic int slot_of(logic [AW-1:0] pc);
    return int'((pc / 4) % NENT);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [AW-1:0] fpc, input bit uv, input bit ut,
                      input logic [AW-1:0] upc, input logic [AW-1:0] utgt, input string req);
    int s;
    bit ehit;
    logic [AW-1:0] epred;
    @(negedge clk);
    fetch_pc = fpc; upd_valid = uv; upd_taken = ut; upd_pc = upc; upd_target = utgt;
    #1;
    s = slot_of(fpc);
    ehit  = ref_v[s] && (ref_pc[s] == fpc);
    epred = ehit ? ref_tgt[s] : fpc + 32'd4;
    chk(pred_hit == ehit, req, "hit", {31'd0, pred_hit}, {31'd0, ehit});
    chk(pred_pc == epred, req, "pred_pc", pred_pc, epred);
    @(posedge clk);
    if (uv && ut) begin
      s = slot_of(upc);
      ref_v[s] = 1'b1; ref_pc[s] = upc; ref_tgt[s] = utgt;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT; i++) begin ref_v[i] = 0; ref_pc[i] = '0; ref_tgt[i] = '0; end
    // Reset with a taken update pending: it must not install anything.
    upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = 32'h100; upd_target = 32'h900;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; upd_valid = 1'b0;

    // R5: empty after reset, every slot misses
    for (int i = 0; i < NENT; i++) step(32'h100 + i*4, 0, 0, '0, '0, "R5");

    // R3: sequential fallback including wrap-around
    step(32'hFFFF_FFFC, 0, 0, '0, '0, "R3");
    step(32'h0000_0002, 0, 0, '0, '0, "R3");

    // R6: install; same-cycle lookup sees old, next cycle sees new
    step(32'h0000_1010, 1, 1, 32'h0000_1010, 32'h0000_4000, "R6");
    step(32'h0000_1010, 0, 0, '0, '0, "R6");
    // R4: exact match only; same slot, different upper bits misses
    step(32'h0000_1050, 0, 0, '0, '0, "R4");
    step(32'h0000_1011, 0, 0, '0, '0, "R4");
    // R7: not-taken and invalid updates change nothing
    step(32'h0000_1010, 1, 0, 32'h0000_1010, 32'h0000_7777, "R7");
    step(32'h0000_1010, 0, 1, 32'h0000_1010, 32'h0000_7777, "R7");
    step(32'h0000_1010, 0, 0, '0, '0, "R7");
    // R8: alias replaces older branch (R2 slot shared)
    step(32'h0000_1010, 1, 1, 32'h0000_1050, 32'h0000_5000, "R8");
    step(32'h0000_1010, 0, 0, '0, '0, "R8");
    step(32'h0000_1050, 0, 0, '0, '0, "R8");
    // R6: retarget a live entry, same-cycle old target
    step(32'h0000_1050, 1, 1, 32'h0000_1050, 32'h0000_6000, "R6");
    step(32'h0000_1050, 0, 0, '0, '0, "R6");

    // R1: mixed random traffic on a pool with three aliases per slot
    for (int n = 0; n < 2000; n++) begin
      logic [AW-1:0] f, u;
      f = 32'h2000 + ($urandom % 48) * 4;
      u = 32'h2000 + ($urandom % 48) * 4;
      step(f, ($urandom % 4) != 0, ($urandom % 2) == 1, u, $urandom & 32'hFFFF_FFFC, "R1");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule